// File: doc/BRIEF.md
# Four-Bit Accumulator Processor

This block is a small single-cycle processor with a 4-bit data path. It holds two general registers, a 4-bit output register that drives four LEDs directly, a 4-bit program counter and a one-bit carry flag. Its program sits in a 16-word instruction store, which a loader fills through a write port while the core is held in reset.

Every instruction is carried out by a single 4-bit adder. A selector picks one of four operands: register A, register B, the input port, or zero. The adder adds the instruction's immediate to that operand. The sum goes to exactly one destination: A, B, the output register or the program counter.

Moves, input reads and output writes are additions with a chosen source and target. Jumps write the sum into the program counter. The conditional jump does so only while the registered carry is clear.

Top module: `acc4_core`

## Requirements
- R1: A clock edge with `rst` high clears A, B, the output register (so `led` reads 0000), the program counter and the carry flag. The first instruction after reset is fetched from address 0.
- R2: An instruction word is 8 bits wide. Bits 7:4 hold the opcode and bits 3:0 hold the immediate. A clock edge with `rom_we` high stores `rom_wdata` at word `rom_addr` of the 16-word store.
- R3: Each instruction writes (operand + immediate) mod 16 to its destination. The carry flag takes the adder's carry-out on every defined instruction.
- R4: These opcodes write A: 0000 A+imm, 0001 B+imm, 0011 imm. These opcodes write B: 0100 A+imm, 0101 B+imm, 0111 imm.
- R5: Opcode 0010 writes `in_port`+imm to A, and opcode 0110 writes `in_port`+imm to B. The port is sampled at the executing edge.
- R6: Opcode 1001 writes B+imm to the output register and opcode 1011 writes imm to it. `led[i]` equals bit i of the output register.
- R7: Opcode 1111 loads the immediate into the program counter.
- R8: Opcode 1110 loads the immediate into the program counter when the registered carry is 0. When the carry is 1, the program counter advances by one.
- R9: An instruction that does not load the program counter advances it by one, and the counter wraps from 15 to 0.
- R10: Any other opcode changes none of A, B or the output register, clears the carry flag and advances the program counter.
- R11: The 16-word counting program shows 0111 on `led` for instructions 1 to 65 and 0110 for instructions 66 to 130. From instruction 131 to 194 it alternates, showing 0000 on the instructions where (n-131) mod 4 is 0 and 0100 on the others. From instruction 195 onward it shows 1000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one instruction per rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_port | input | 4 | Input switches read by the input opcodes |
| rom_we | input | 1 | Instruction store write enable |
| rom_addr | input | 4 | Instruction store write address |
| rom_wdata | input | 8 | Instruction word to store |
| led | output | 4 | Output register, one bit per LED |

## Verification
Each instruction takes effect at the rising edge that executes it. The program counter, registers and `led` all update on that same edge. An instruction's result therefore appears on `led` after exactly n rising edges, where n is its position in the executed sequence counted from reset release. The bench changes inputs and samples `led` only on falling edges. It counts one falling edge per executed instruction, so every expected value is compared at the half-cycle right after the edge that produced it. Register contents and jump outcomes are brought out through short programs that copy them to `led` a known number of instructions later.

// File: rtl/acc4_core.sv
module acc4_core (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] in_port,
  input  logic       rom_we,
  input  logic [3:0] rom_addr,
  input  logic [7:0] rom_wdata,
  output logic [3:0] led
);
  localparam logic [1:0] SRC_A = 2'd0, SRC_B = 2'd1, SRC_IN = 2'd2, SRC_ZERO = 2'd3;
  localparam logic [1:0] DST_A = 2'd0, DST_B = 2'd1, DST_O = 2'd2, DST_P = 2'd3;
  localparam logic [3:0] OP_JNC = 4'hE, OP_JMP = 4'hF;

  logic [7:0] rom [16];
  logic [3:0] a, b, out_r, pc;
  logic       cf;

  logic [7:0] instr;
  logic [3:0] op, imm, src_v, pc_next;
  logic [1:0] src, dst;
  logic       valid, load_pc;
  logic [4:0] sum;

  always_ff @(posedge clk)
    if (rom_we) rom[rom_addr] <= rom_wdata;

  assign instr = rom[pc];
  assign op    = instr[7:4];
  assign imm   = instr[3:0];

  always_comb begin
    valid = 1'b1;
    src   = SRC_ZERO;
    dst   = DST_A;
    case (op)
      4'h0: begin src = SRC_A;    dst = DST_A; end
      4'h1: begin src = SRC_B;    dst = DST_A; end
      4'h2: begin src = SRC_IN;   dst = DST_A; end
      4'h3: begin src = SRC_ZERO; dst = DST_A; end
      4'h4: begin src = SRC_A;    dst = DST_B; end
      4'h5: begin src = SRC_B;    dst = DST_B; end
      4'h6: begin src = SRC_IN;   dst = DST_B; end
      4'h7: begin src = SRC_ZERO; dst = DST_B; end
      4'h9: begin src = SRC_B;    dst = DST_O; end
      4'hB: begin src = SRC_ZERO; dst = DST_O; end
      OP_JNC, OP_JMP: begin src = SRC_ZERO; dst = DST_P; end
      default: valid = 1'b0;
    endcase
  end

  always_comb
    case (src)
      SRC_A:   src_v = a;
      SRC_B:   src_v = b;
      SRC_IN:  src_v = in_port;
      default: src_v = 4'd0;
    endcase

  assign sum     = {1'b0, src_v} + {1'b0, imm};
  assign load_pc = valid && dst == DST_P && !(op == OP_JNC && cf);
  assign pc_next = load_pc ? sum[3:0] : pc + 4'd1;

  always_ff @(posedge clk) begin
    if (rst) begin
      a     <= '0;
      b     <= '0;
      out_r <= '0;
      pc    <= '0;
      cf    <= 1'b0;
    end else begin
      pc <= pc_next;
      cf <= valid & sum[4];
      if (valid && dst == DST_A) a     <= sum[3:0];
      if (valid && dst == DST_B) b     <= sum[3:0];
      if (valid && dst == DST_O) out_r <= sum[3:0];
    end
  end

  assign led = out_r;

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk)
    if (rst_d === 1'b1)
      assert_reset_state_R1: assert (a == 0 && b == 0 && out_r == 0 && pc == 0 && !cf)
        else $error("state not cleared after reset");

  assert_add_carry_R3: assert property (@(posedge clk) disable iff (rst)
    (op == 4'h0) |=> (cf == ($past(a) > ~$past(imm))));

  assert_out_imm_R6: assert property (@(posedge clk) disable iff (rst)
    (op == 4'hB) |=> (led == $past(imm)));

  assert_jmp_R7: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JMP) |=> (pc == $past(imm)));

  assert_jnc_taken_R8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JNC && !cf) |=> (pc == $past(imm)));

  assert_jnc_skip_R8: assert property (@(posedge clk) disable iff (rst)
    (op == OP_JNC && cf) |=> (pc == $past(pc) + 4'd1));

  assert_pc_step_R9: assert property (@(posedge clk) disable iff (rst)
    (op != OP_JNC && op != OP_JMP) |=> (pc == $past(pc) + 4'd1));

  assert_undef_nop_R10: assert property (@(posedge clk) disable iff (rst)
    !valid |=> (!cf && $stable(a) && $stable(b) && $stable(led)));
endmodule

// File: tb/tb_acc4_core.sv
module tb_acc4_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] in_port = 4'd0;
  logic       rom_we = 1'b0;
  logic [3:0] rom_addr = 4'd0;
  logic [7:0] rom_wdata = 8'd0;
  logic [3:0] led;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] prog [16];

  always #2 clk = ~clk;

  acc4_core dut (
    .clk(clk), .rst(rst), .in_port(in_port), .rom_we(rom_we),
    .rom_addr(rom_addr), .rom_wdata(rom_wdata), .led(led)
  );

  task automatic chk(input string req, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: led=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic fill(input logic [7:0] v);
    for (int i = 0; i < 16; i++) prog[i] = v;
  endtask

  task automatic load();
    rst = 1'b1;
    for (int i = 0; i < 16; i++) begin
      rom_we = 1'b1;
      rom_addr = 4'(i);
      rom_wdata = prog[i];
      @(negedge clk);
    end
    rom_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    fill(8'hBF);
    prog[0] = 8'h39; prog[1] = 8'h76; prog[2] = 8'hB3; prog[3] = 8'h0F; prog[4] = 8'hF4;
    load();
    chk("R1 led during reset", led, 4'b0000);
    rst = 1'b0;
    run(4);
    chk("R6 OUT imm before reset", led, 4'b0011);
    fill(8'hBF);
    prog[0] = 8'hE3; prog[2] = 8'hF2; prog[3] = 8'h90; prog[4] = 8'h40;
    prog[5] = 8'h90; prog[6] = 8'hF6;
    load();
    chk("R1 output register cleared", led, 4'b0000);
    rst = 1'b0;
    run(2);
    chk("R1 carry and B cleared", led, 4'b0000);
    run(2);
    chk("R1 A cleared", led, 4'b0000);
  endtask

  task automatic t_moves();
    fill(8'hBF);
    prog[0] = 8'h35; prog[1] = 8'h04; prog[2] = 8'h42; prog[3] = 8'h90;
    prog[4] = 8'h57; prog[5] = 8'hE9; prog[6] = 8'h90; prog[7] = 8'h11;
    prog[8] = 8'h40; prog[9] = 8'h90; prog[10] = 8'hFA;
    load();
    rst = 1'b0;
    run(4);
    chk("R4 MOV A,imm / ADD A / MOV B,A+imm", led, 4'b1011);
    run(3);
    chk("R3 ADD B wraps and sets carry, R8 JNC skipped", led, 4'b0010);
    run(3);
    chk("R4 MOV A,B+imm then MOV B,A", led, 4'b0011);
    run(4);
    chk("R7 JMP self loop holds output", led, 4'b0011);
  endtask

  task automatic t_input();
    fill(8'hBF);
    prog[0] = 8'h21; prog[1] = 8'h40; prog[2] = 8'h90; prog[3] = 8'h60;
    prog[4] = 8'h90; prog[5] = 8'hF5;
    load();
    in_port = 4'd6;
    rst = 1'b0;
    run(3);
    chk("R5 IN A plus immediate", led, 4'b0111);
    in_port = 4'hD;
    run(2);
    chk("R5 IN B", led, 4'b1101);
    in_port = 4'd0;
  endtask

  task automatic t_jumps();
    fill(8'hBF);
    prog[0] = 8'h3E; prog[1] = 8'h01; prog[2] = 8'hE5; prog[3] = 8'hB1; prog[4] = 8'hF4;
    prog[5] = 8'hB2; prog[6] = 8'h01; prog[7] = 8'hE3; prog[8] = 8'hB4; prog[9] = 8'hFE;
    prog[14] = 8'hB8; prog[15] = 8'h79;
    load();
    rst = 1'b0;
    run(3);
    chk("R2 word layout, OUT not yet reached", led, 4'b0000);
    run(1);
    chk("R8 JNC taken with carry clear", led, 4'b0010);
    run(3);
    chk("R8 JNC not taken with carry set", led, 4'b0100);
    run(2);
    chk("R7 JMP to 14", led, 4'b1000);
    run(2);
    chk("R9 wrap 15 to 0 keeps output", led, 4'b1000);
    run(3);
    chk("R9 program restarted at 0 after wrap", led, 4'b0010);
  endtask

  task automatic t_undefined();
    fill(8'hBF);
    prog[0] = 8'h3F; prog[1] = 8'h75; prog[2] = 8'hB6; prog[3] = 8'h01;
    prog[4] = 8'h8A; prog[5] = 8'hE8; prog[6] = 8'hBF; prog[7] = 8'hF7;
    prog[8] = 8'h90; prog[9] = 8'h40; prog[10] = 8'hA9; prog[11] = 8'hC3;
    prog[12] = 8'hD1; prog[13] = 8'h8F; prog[14] = 8'h90; prog[15] = 8'hFF;
    load();
    rst = 1'b0;
    run(5);
    chk("R10 undefined leaves output", led, 4'b0110);
    run(1);
    chk("R10 undefined clears carry", led, 4'b0110);
    run(1);
    chk("R10 undefined leaves B", led, 4'b0101);
    run(5);
    chk("R10 undefined run leaves output", led, 4'b0101);
    run(1);
    chk("R10 undefined run leaves A and B", led, 4'b0000);
  endtask

  function automatic logic [3:0] ref_led(input int n);
    if (n <= 65) return 4'b0111;
    if (n <= 130) return 4'b0110;
    if (n <= 194) return ((n - 131) % 4 == 0) ? 4'b0000 : 4'b0100;
    return 4'b1000;
  endfunction

  task automatic t_counting_program();
    logic [7:0] p [16] = '{8'hB7, 8'h01, 8'hE1, 8'h01, 8'hE3, 8'hB6, 8'h01, 8'hE6,
                           8'h01, 8'hE8, 8'hB0, 8'hB4, 8'h01, 8'hEA, 8'hB8, 8'hFF};
    for (int i = 0; i < 16; i++) prog[i] = p[i];
    load();
    rst = 1'b0;
    for (int n = 1; n <= 210; n++) begin
      run(1);
      chk($sformatf("R11 counting program step %0d", n), led, ref_led(n));
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_moves();
    t_input();
    t_jumps();
    t_undefined();
    t_counting_program();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule